// File: doc/BRIEF.md
# Equalizer Mode and Bypass Arbiter

This block is the control logic of an adaptive cable-equalizer front end. It reduces the pin straps, configuration register fields, a signal-present flag and a detected-rate code to a small set of registered control levels: equalizer power-down, output mute, equalizer bypass, a combined jitter-cleaner bypass/power-down, and one enable per output driver. The analog equalizer, the clock recovery loop and the drivers consume these levels and are not part of the block.

A mode input selects the source of control. With it low, the multifunction pins govern the block: a three-level bypass strap, an auto-sleep strap and a mute strap. With it high, register fields govern it instead. In both modes one precedence applies: sleep overrides mute, and mute overrides bypass. The jitter cleaner is switched off by itself whenever the detected rate is standard definition or cannot be determined. Driver enables come from per-driver swing fields, and a dedicated pin can force the second driver off.

Top module: `eqa_arbiter`

## Requirements
- R1: While reset is asserted, and afterwards until the first clock edge, the outputs are eq_pd=1, out_mute=1, eq_bypass=0, jc_off=1 and every drv_en bit is 0.
- R2: When sw_mode=0, the equalizer is powered down (eq_pd=1) when asleep_pin=1 and sig_det=0. With asleep_pin=0 it stays powered whatever sig_det is.
- R3: When sw_mode=0, byp_lvl encodes the three-level strap: 2'b00 (driven low) is normal operation, 2'b01 (driven high) sets both eq_bypass and jc_off, 2'b10 (floating) sets only jc_off, and 2'b11 is treated as driven high.
- R4: When sw_mode=1, sleep_code selects the power state: 2'b00 keeps the equalizer on, 2'b01 powers it down only while sig_det=0, 2'b10 always powers it down, and the reserved 2'b11 keeps it on.
- R5: Sleep overrides mute and bypass, and mute overrides bypass. Whenever eq_pd=1, out_mute=1 and eq_bypass=0. Whenever out_mute=1, eq_bypass=0, and a bypass request does not reach jc_off.
- R6: In either mode, jc_off=1 whenever rate_code is 2'b00 (SD) or 2'b11 (rate unknown). Rate codes 2'b01 (HD) and 2'b10 (3G) leave the jitter cleaner running unless something else turns it off.
- R7: When sw_mode=1, reg_bypass=1 sets eq_bypass and jc_off, and reg_jc_bypass=1 sets jc_off alone.
- R8: drv_en[i] is 1 exactly when the swing field of driver i, swing_cfg[i*2+1:i*2], is not 2'b00. drv1_off_pin=1 forces drv_en[1] to 0 in both modes.
- R9: Every output is registered. A change at the inputs, including a change of sw_mode, appears on the outputs after the next rising clock edge and not before.
- R10: Register fields (sleep_code, reg_mute, reg_bypass, reg_jc_bypass) have no effect when sw_mode=0. The straps (byp_lvl, asleep_pin, mute_pin) have no effect when sw_mode=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_mode | input | 1 | 0: straps control, 1: registers control |
| byp_lvl | input | 2 | Decoded three-level bypass strap |
| asleep_pin | input | 1 | Auto-sleep strap |
| mute_pin | input | 1 | Mute strap |
| sig_det | input | 1 | Input signal present (active high) |
| sleep_code | input | 2 | Register sleep field |
| reg_mute | input | 1 | Register mute bit |
| reg_bypass | input | 1 | Register equalizer bypass bit |
| reg_jc_bypass | input | 1 | Register jitter-cleaner bypass bit |
| rate_code | input | 2 | Detected rate: 00 SD, 01 HD, 10 3G, 11 unknown |
| drv1_off_pin | input | 1 | Forces driver 1 off |
| swing_cfg | input | NDRV*SW_W | Packed per-driver swing fields |
| eq_pd | output | 1 | Equalizer power-down |
| out_mute | output | 1 | Output mute |
| eq_bypass | output | 1 | Equalizer bypass |
| jc_off | output | 1 | Jitter cleaner bypassed and powered down |
| drv_en | output | NDRV | Per-driver enable |

## Verification
The table drives each mode with its own controls active while the other mode's controls are set to conflicting values. This separates a correct mode multiplexer from one that mixes the two sources. The strap and sleep-code patterns cover every code, including the floating strap and the reserved sleep code. Paired conflicts (sleep with mute and bypass, mute with bypass) show whether the precedence order is right. The rate codes are each tried with no other bypass request, so an auto-bypass that misses SD or the unknown code shows up on its own. Directed steps check the reset values and show that an input change is invisible before the clock edge and visible after it.

// File: rtl/eqa_pkg.sv
package eqa_pkg;

   typedef enum logic [1:0] {
      BYP_LOW   = 2'b00,
      BYP_HIGH  = 2'b01,
      BYP_FLOAT = 2'b10,
      BYP_RSVD  = 2'b11
   } byp_lvl_e;

   typedef enum logic [1:0] {
      SLP_ON   = 2'b00,
      SLP_AUTO = 2'b01,
      SLP_OFF  = 2'b10,
      SLP_RSVD = 2'b11
   } sleep_code_e;

   typedef enum logic [1:0] {
      RATE_SD  = 2'b00,
      RATE_HD  = 2'b01,
      RATE_3G  = 2'b10,
      RATE_UNK = 2'b11
   } rate_e;

   typedef struct packed {
      logic sleep;
      logic mute;
      logic eq_byp;
      logic jc_byp;
   } ctl_req_t;

   typedef struct packed {
      logic eq_pd;
      logic out_mute;
      logic eq_bypass;
      logic jc_off;
   } ctl_out_t;

   localparam ctl_out_t CTL_RESET = '{eq_pd: 1'b1, out_mute: 1'b1,
                                      eq_bypass: 1'b0, jc_off: 1'b1};

endpackage

// File: rtl/eqa_req_decode.sv
module eqa_req_decode
   import eqa_pkg::*;
(
   input  logic     sw_mode,
   input  logic [1:0] byp_lvl,
   input  logic     asleep_pin,
   input  logic     mute_pin,
   input  logic     sig_det,
   input  logic [1:0] sleep_code,
   input  logic     reg_mute,
   input  logic     reg_bypass,
   input  logic     reg_jc_bypass,
   output ctl_req_t req
);

   ctl_req_t hw_req;
   ctl_req_t sw_req;

   // strap decode
   always_comb begin
      hw_req        = '0;
      hw_req.sleep  = asleep_pin & ~sig_det;
      hw_req.mute   = mute_pin;
      unique case (byp_lvl_e'(byp_lvl))
         BYP_LOW:   begin hw_req.eq_byp = 1'b0; hw_req.jc_byp = 1'b0; end
         BYP_FLOAT: begin hw_req.eq_byp = 1'b0; hw_req.jc_byp = 1'b1; end
         default:   begin hw_req.eq_byp = 1'b1; hw_req.jc_byp = 1'b1; end
      endcase
   end

   // register decode
   always_comb begin
      sw_req        = '0;
      sw_req.mute   = reg_mute;
      sw_req.eq_byp = reg_bypass;
      sw_req.jc_byp = reg_bypass | reg_jc_bypass;
      unique case (sleep_code_e'(sleep_code))
         SLP_AUTO: sw_req.sleep = ~sig_det;
         SLP_OFF:  sw_req.sleep = 1'b1;
         default:  sw_req.sleep = 1'b0;
      endcase
   end

   assign req = sw_mode ? sw_req : hw_req;

endmodule

// File: rtl/eqa_prec.sv
module eqa_prec
   import eqa_pkg::*;
(
   input  ctl_req_t   req,
   input  logic [1:0] rate_code,
   output ctl_out_t   ctl
);

   logic rate_no_jc;
   logic byp_allowed;

   assign rate_no_jc  = (rate_e'(rate_code) == RATE_SD) ||
                        (rate_e'(rate_code) == RATE_UNK);
   assign byp_allowed = ~req.sleep & ~req.mute;

   always_comb begin
      ctl.eq_pd     = req.sleep;
      ctl.out_mute  = req.sleep | req.mute;
      ctl.eq_bypass = byp_allowed & req.eq_byp;
      ctl.jc_off    = req.sleep | rate_no_jc | (byp_allowed & req.jc_byp);
   end

endmodule

// File: rtl/eqa_drv_gate.sv
module eqa_drv_gate #(
   parameter int SW_W = 2
) (
   input  logic [SW_W-1:0] swing,
   input  logic            force_off,
   output logic            en
);

   assign en = (|swing) & ~force_off;

endmodule

// File: rtl/eqa_arbiter.sv
module eqa_arbiter
   import eqa_pkg::*;
#(
   parameter int NDRV = 2,
   parameter int SW_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sw_mode,
   input  logic [1:0]           byp_lvl,
   input  logic                 asleep_pin,
   input  logic                 mute_pin,
   input  logic                 sig_det,
   input  logic [1:0]           sleep_code,
   input  logic                 reg_mute,
   input  logic                 reg_bypass,
   input  logic                 reg_jc_bypass,
   input  logic [1:0]           rate_code,
   input  logic                 drv1_off_pin,
   input  logic [NDRV*SW_W-1:0] swing_cfg,
   output logic                 eq_pd,
   output logic                 out_mute,
   output logic                 eq_bypass,
   output logic                 jc_off,
   output logic [NDRV-1:0]      drv_en
);

   localparam int CFG_W = NDRV * SW_W;

   if (NDRV < 1 || NDRV > 2) begin : g_bad_ndrv
      $error("eqa_arbiter: NDRV must be 1 or 2");
   end
   if (SW_W < 1) begin : g_bad_sww
      $error("eqa_arbiter: SW_W must be at least 1");
   end

   ctl_req_t  req;
   ctl_out_t  ctl_d;
   ctl_out_t  ctl_q;
   logic [NDRV-1:0] drv_d;
   logic [NDRV-1:0] drv_q;
   logic [NDRV-1:0] drv_force;

   eqa_req_decode u_dec (
      .sw_mode       (sw_mode),
      .byp_lvl       (byp_lvl),
      .asleep_pin    (asleep_pin),
      .mute_pin      (mute_pin),
      .sig_det       (sig_det),
      .sleep_code    (sleep_code),
      .reg_mute      (reg_mute),
      .reg_bypass    (reg_bypass),
      .reg_jc_bypass (reg_jc_bypass),
      .req           (req)
   );

   eqa_prec u_prec (
      .req       (req),
      .rate_code (rate_code),
      .ctl       (ctl_d)
   );

   for (genvar i = 0; i < NDRV; i++) begin : g_drv
      if (i == 1) begin : g_ovr
         assign drv_force[i] = drv1_off_pin;
      end else begin : g_free
         assign drv_force[i] = 1'b0;
      end
      eqa_drv_gate #(.SW_W(SW_W)) u_gate (
         .swing     (swing_cfg[i*SW_W +: SW_W]),
         .force_off (drv_force[i]),
         .en        (drv_d[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_RESET;
         drv_q <= '0;
      end else begin
         ctl_q <= ctl_d;
         drv_q <= drv_d;
      end
   end

   assign eq_pd     = ctl_q.eq_pd;
   assign out_mute  = ctl_q.out_mute;
   assign eq_bypass = ctl_q.eq_bypass;
   assign jc_off    = ctl_q.jc_off;
   assign drv_en    = drv_q;

   // R5
   prec_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eq_pd |-> (out_mute && !eq_bypass));

   // R5
   prec_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_mute |-> !eq_bypass);

   // R6
   jc_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_code == RATE_SD || rate_code == RATE_UNK) |=> jc_off);

   // R2
   hw_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_mode && asleep_pin && !sig_det) |=> eq_pd);

   // R4
   sw_forced_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_mode && sleep_code == SLP_OFF) |=> eq_pd);

   // R8
   drv0_swing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (swing_cfg[SW_W-1:0] == '0) |=> !drv_en[0]);

   if (NDRV > 1) begin : g_ovr_chk
      // R8
      drv1_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         drv1_off_pin |=> !drv_en[NDRV-1]);
   end

   wire unused_cfg_w = (CFG_W == 0);

endmodule

// File: tb/eqa_arbiter_test.sv
module eqa_arbiter_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_mode = 1'b0;
   logic [1:0] byp_lvl = 2'b00;
   logic       asleep_pin = 1'b0;
   logic       mute_pin = 1'b0;
   logic       sig_det = 1'b0;
   logic [1:0] sleep_code = 2'b00;
   logic       reg_mute = 1'b0;
   logic       reg_bypass = 1'b0;
   logic       reg_jc_bypass = 1'b0;
   logic [1:0] rate_code = 2'b01;
   logic       drv1_off_pin = 1'b0;
   logic [3:0] swing_cfg = 4'b1010;
   logic       eq_pd, out_mute, eq_bypass, jc_off;
   logic [1:0] drv_en;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   eqa_arbiter uut (
      .clk(clk), .rst_n(rst_n), .sw_mode(sw_mode), .byp_lvl(byp_lvl),
      .asleep_pin(asleep_pin), .mute_pin(mute_pin), .sig_det(sig_det),
      .sleep_code(sleep_code), .reg_mute(reg_mute), .reg_bypass(reg_bypass),
      .reg_jc_bypass(reg_jc_bypass), .rate_code(rate_code),
      .drv1_off_pin(drv1_off_pin), .swing_cfg(swing_cfg),
      .eq_pd(eq_pd), .out_mute(out_mute), .eq_bypass(eq_bypass),
      .jc_off(jc_off), .drv_en(drv_en)
   );

   // [27:24] requirement, [23:6] inputs:
   // mode, byp[2], asleep, mute_pin, sig, sleep[2], rmute, rbyp, rjc, rate[2], d1off, sw1[2], sw0[2]
   // [5:0] expected: pd, mute, bypass, jc_off, drv1, drv0
   localparam int NV = 21;
   localparam logic [27:0] VEC [NV] = '{
      28'b0010_0_00_1_0_1_00_0_0_0_01_0_10_10_0_0_0_0_11, // R2 auto-sleep, signal present
      28'b0010_0_00_1_0_0_00_0_0_0_01_0_10_10_1_1_0_1_11, // R2 auto-sleep, no signal
      28'b0010_0_00_0_0_0_00_0_0_0_01_0_10_10_0_0_0_0_11, // R2 sleep strap low
      28'b0011_0_01_0_0_1_00_0_0_0_01_0_10_10_0_0_1_1_11, // R3 strap high
      28'b0011_0_10_0_0_1_00_0_0_0_01_0_10_10_0_0_0_1_11, // R3 strap floating
      28'b0101_0_01_0_1_1_00_0_0_0_01_0_10_10_0_1_0_0_11, // R5 mute over bypass
      28'b0101_0_01_1_1_0_00_0_0_0_01_0_10_10_1_1_0_1_11, // R5 sleep over all
      28'b0110_0_00_0_0_1_00_0_0_0_00_0_10_10_0_0_0_1_11, // R6 SD rate
      28'b0110_0_00_0_0_1_00_0_0_0_11_0_10_10_0_0_0_1_11, // R6 unknown rate
      28'b1010_0_00_0_0_1_10_1_1_1_10_0_10_10_0_0_0_0_11, // R10 registers ignored
      28'b1010_1_01_1_1_0_00_0_0_0_10_0_10_10_0_0_0_0_11, // R10 straps ignored
      28'b0100_1_00_0_0_0_01_0_0_0_10_0_10_10_1_1_0_1_11, // R4 auto, no signal
      28'b0100_1_00_0_0_1_01_0_0_0_10_0_10_10_0_0_0_0_11, // R4 auto, signal
      28'b0100_1_00_0_0_1_10_0_0_0_10_0_10_10_1_1_0_1_11, // R4 forced off
      28'b0100_1_00_0_0_0_11_0_0_0_10_0_10_10_0_0_0_0_11, // R4 reserved code
      28'b0111_1_00_0_0_1_00_0_1_0_10_0_10_10_0_0_1_1_11, // R7 reg bypass
      28'b0111_1_00_0_0_1_00_0_0_1_10_0_10_10_0_0_0_1_11, // R7 reg jc bypass
      28'b0101_1_00_0_0_1_00_1_1_0_10_0_10_10_0_1_0_0_11, // R5 reg mute over bypass
      28'b1000_1_00_0_0_1_00_0_0_0_10_0_00_11_0_0_0_0_01, // R8 swing 00 off
      28'b1000_0_00_0_0_1_00_0_0_0_10_1_11_00_0_0_0_0_00, // R8 pin override
      28'b1000_0_00_0_0_1_00_0_0_0_10_0_01_01_0_0_0_0_11  // R8 low swing on
   };

   task automatic check(input int req, input logic [5:0] exp);
      logic [5:0] act;
      act = {eq_pd, out_mute, eq_bypass, jc_off, drv_en};
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic apply(input logic [17:0] v);
      {sw_mode, byp_lvl, asleep_pin, mute_pin, sig_det, sleep_code, reg_mute,
       reg_bypass, reg_jc_bypass, rate_code, drv1_off_pin, swing_cfg} = v;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(1, 6'b110100); // R1 during reset
      rst_n = 1'b1;
      #1 check(1, 6'b110100); // R1 before first edge
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         apply(VEC[i][23:6]);
         @(negedge clk);
         check(int'(VEC[i][27:24]), VEC[i][5:0]);
      end
      // R9: mode change visible only after the edge
      @(negedge clk);
      apply(18'b0_00_0_0_1_00_0_0_0_10_0_10_10);
      @(negedge clk);
      check(9, 6'b000011);
      sw_mode = 1'b1; sleep_code = 2'b10;
      #1 check(9, 6'b000011);
      @(negedge clk);
      check(9, 6'b110111);
      // R1 reset in mid-run
      rst_n = 1'b0;
      #1 check(1, 6'b110100);
      @(negedge clk);
      check(1, 6'b110100);
      rst_n = 1'b1;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule